// File: doc/BRIEF.md
# Link Training Bring-Up Supervisor

This block brings a serial link out of reset and judges when it is fit to carry traffic. On a start request it raises the enable of an external training state machine. It then samples three inputs once per poll interval: the 6-bit training state, the enable as read back from that machine, and the PHY's own link-up flag. The link counts as usable only when the sampled training state is the active state (code 0x11). The PHY flag alone is never enough, because it can assert while training is stuck in a recovery state.

An attempt fails in two ways. The read-back enable may be found cleared, which the training machine does on its own after an unsuccessful run. Or the poll budget may run out before the active state appears. After a failure the supervisor drops the enable for a hold period and then raises it again, up to a bounded number of attempts. It can optionally lower the advertised speed cap to the lowest generation before the retry. Once every attempt is used up it reports a sticky failure. If the link leaves the active state after it was declared up, the block reports the loss and returns to idle without retraining.

Top module: `lnk_bringup_sup`

## Requirements
- R1: After reset, trn_en_o, link_up_o, link_lost_o and link_fail_o are 0, attempt_o and last_state_o are 0, and speed_cap_o equals CAP_TOP (2 by default).
- R2: A start_i seen in idle raises trn_en_o at that same clock edge, with attempt_o = 1 and speed_cap_o = CAP_TOP. A start_i seen while training, holding, up or failed has no effect.
- R3: The inputs are sampled once every POLL_CYC cycles, counted from the edge at which trn_en_o rises. At each sample last_state_o takes the sampled training state.
- R4: link_up_o rises at the sampling edge where the training state equals 0x11, the read-back enable is 1 and the PHY flag is 1. A PHY flag of 1 with any other state (for example 0x0E, recovery speed) never raises link_up_o.
- R5: A read-back enable of 0 at a sample ends the attempt as failed, and trn_en_o falls at that sampling edge.
- R6: If POLLS samples pass without the active state, the attempt fails at the POLLS-th sampling edge. The active state found on that last sample is accepted as link-up and is not treated as a failure.
- R7: After a failed attempt with attempts left, trn_en_o stays low for exactly HOLD_CYC cycles and then rises, with attempt_o incremented by one.
- R8: If fallback_i is 1 when an attempt fails and is retried, speed_cap_o becomes CAP_LOW (1) at that edge and stays there until the next start. With fallback_i at 0 the cap stays at CAP_TOP.
- R9: A failure on attempt MAX_ATT sets link_fail_o. link_fail_o stays set until reset, trn_en_o stays 0, and attempt_o stays at MAX_ATT. A later start_i is ignored.
- R10: While up, a sample that is not the qualified active state drops link_up_o and trn_en_o at that edge. link_lost_o is then high for exactly one cycle, no further attempt is started, and the block waits in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a bring-up sequence from idle |
| fallback_i | input | 1 | Lower the speed cap when an attempt is retried |
| trn_state_i | input | ST_W | Training state reported by the link state machine |
| trn_en_rb_i | input | 1 | Training enable as read back from the state machine |
| phy_up_i | input | 1 | PHY link-up flag |
| trn_en_o | output | 1 | Training enable |
| speed_cap_o | output | CAP_W | Advertised maximum speed generation |
| link_up_o | output | 1 | Link qualified as usable |
| link_lost_o | output | 1 | One-cycle pulse when a qualified link drops |
| link_fail_o | output | 1 | Sticky: all attempts exhausted |
| attempt_o | output | ATT_W | Number of the current or last attempt |
| last_state_o | output | ST_W | Training state at the most recent sample |

## Verification
Two decisions can land on the same sampling edge: the active state can first appear on the very sample that also uses up the poll budget, and a self-cleared enable or a timeout can fall on the final permitted attempt. Directed runs place the active state exactly on the last poll of the last attempt. There link_up_o must rise at that edge, and no failure or drop of the enable may follow. Other runs end the last attempt with a cleared enable or a stuck recovery state, where the same edge must raise link_fail_o. Random runs mix these outcomes with varied arrival times, fallback settings and post-link drops. Each attempt's enable-high length, each hold gap and the final status are compared with values derived from the poll interval.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [2:0] {
        SUP_IDLE,
        SUP_TRAIN,
        SUP_HOLD,
        SUP_UP,
        SUP_FAIL
    } sup_state_e;

    typedef enum logic [1:0] {
        SMP_PROGRESS,
        SMP_ACTIVE,
        SMP_DROPPED
    } smp_verdict_e;

endpackage

// File: rtl/lbs_interval_timer.sv
module lbs_interval_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    generate
        if (LIMIT <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = run && (cnt_q == CW'(LIMIT - 1));
                cnt_d = cnt_q;
                if (!run || tick) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lbs_sample_judge.sv
module lbs_sample_judge
    import lbs_pkg::*;
#(
    parameter int unsigned       ST_W        = 6,
    parameter logic [ST_W-1:0]   ACTIVE_CODE = 6'h11
) (
    input  logic [ST_W-1:0] state_i,
    input  logic            en_rb_i,
    input  logic            phy_up_i,
    output smp_verdict_e    verdict_o
);
    // The PHY flag only counts together with the active training state.
    always_comb begin
        if (!en_rb_i) begin
            verdict_o = SMP_DROPPED;
        end else if ((state_i == ACTIVE_CODE) && phy_up_i) begin
            verdict_o = SMP_ACTIVE;
        end else begin
            verdict_o = SMP_PROGRESS;
        end
    end
endmodule

// File: rtl/lnk_bringup_sup.sv
module lnk_bringup_sup
    import lbs_pkg::*;
#(
    parameter int unsigned     POLL_CYC    = 5000,
    parameter int unsigned     POLLS       = 10,
    parameter int unsigned     MAX_ATT     = 4,
    parameter int unsigned     HOLD_CYC    = 64,
    parameter int unsigned     CAP_W       = 2,
    parameter int unsigned     CAP_TOP     = 2,
    parameter int unsigned     CAP_LOW     = 1,
    parameter int unsigned     ST_W        = 6,
    parameter logic [ST_W-1:0] ACTIVE_CODE = 6'h11,
    localparam int unsigned    ATT_W       = $clog2(MAX_ATT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fallback_i,
    input  logic [ST_W-1:0]  trn_state_i,
    input  logic             trn_en_rb_i,
    input  logic             phy_up_i,
    output logic             trn_en_o,
    output logic [CAP_W-1:0] speed_cap_o,
    output logic             link_up_o,
    output logic             link_lost_o,
    output logic             link_fail_o,
    output logic [ATT_W-1:0] attempt_o,
    output logic [ST_W-1:0]  last_state_o
);
    localparam int unsigned PW = (POLLS > 1) ? $clog2(POLLS) : 1;

    typedef struct packed {
        sup_state_e       st;
        logic [PW-1:0]    polls;
        logic [ATT_W-1:0] attempt;
        logic [CAP_W-1:0] cap;
        logic [ST_W-1:0]  last;
        logic             en;
        logic             up;
        logic             lost;
        logic             fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic         poll_tick;
    logic         hold_tick;
    smp_verdict_e verdict;

    lbs_interval_timer #(.LIMIT(POLL_CYC)) i_poll_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((ctl_q.st == SUP_TRAIN) || (ctl_q.st == SUP_UP)),
        .tick  (poll_tick)
    );

    lbs_interval_timer #(.LIMIT(HOLD_CYC)) i_hold_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.st == SUP_HOLD),
        .tick  (hold_tick)
    );

    lbs_sample_judge #(.ST_W(ST_W), .ACTIVE_CODE(ACTIVE_CODE)) i_judge (
        .state_i   (trn_state_i),
        .en_rb_i   (trn_en_rb_i),
        .phy_up_i  (phy_up_i),
        .verdict_o (verdict)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.lost = 1'b0;
        unique case (ctl_q.st)
            SUP_IDLE: begin
                if (start_i) begin
                    ctl_d.st      = SUP_TRAIN;
                    ctl_d.en      = 1'b1;
                    ctl_d.attempt = ATT_W'(1);
                    ctl_d.polls   = '0;
                    ctl_d.cap     = CAP_W'(CAP_TOP);
                end
            end
            SUP_TRAIN: begin
                if (poll_tick) begin
                    ctl_d.last = trn_state_i;
                    if (verdict == SMP_ACTIVE) begin
                        // Active state wins even on the final poll.
                        ctl_d.st = SUP_UP;
                        ctl_d.up = 1'b1;
                    end else if ((verdict == SMP_DROPPED) ||
                                 (ctl_q.polls == PW'(POLLS - 1))) begin
                        ctl_d.en = 1'b0;
                        if (ctl_q.attempt == ATT_W'(MAX_ATT)) begin
                            ctl_d.st   = SUP_FAIL;
                            ctl_d.fail = 1'b1;
                        end else begin
                            ctl_d.st = SUP_HOLD;
                            if (fallback_i) begin
                                ctl_d.cap = CAP_W'(CAP_LOW);
                            end
                        end
                    end else begin
                        ctl_d.polls = ctl_q.polls + 1'b1;
                    end
                end
            end
            SUP_HOLD: begin
                if (hold_tick) begin
                    ctl_d.st      = SUP_TRAIN;
                    ctl_d.en      = 1'b1;
                    ctl_d.attempt = ctl_q.attempt + 1'b1;
                    ctl_d.polls   = '0;
                end
            end
            SUP_UP: begin
                if (poll_tick) begin
                    ctl_d.last = trn_state_i;
                    if (verdict != SMP_ACTIVE) begin
                        ctl_d.st   = SUP_IDLE;
                        ctl_d.up   = 1'b0;
                        ctl_d.en   = 1'b0;
                        ctl_d.lost = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= SUP_IDLE;
            ctl_q.cap     <= CAP_W'(CAP_TOP);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign trn_en_o     = ctl_q.en;
    assign speed_cap_o  = ctl_q.cap;
    assign link_up_o    = ctl_q.up;
    assign link_lost_o  = ctl_q.lost;
    assign link_fail_o  = ctl_q.fail;
    assign attempt_o    = ctl_q.attempt;
    assign last_state_o = ctl_q.last;
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
    parameter int unsigned     MAX_ATT     = 4,
    parameter int unsigned     ATT_W       = 3,
    parameter int unsigned     CAP_W       = 2,
    parameter int unsigned     CAP_TOP     = 2,
    parameter int unsigned     CAP_LOW     = 1,
    parameter int unsigned     ST_W        = 6,
    parameter logic [ST_W-1:0] ACTIVE_CODE = 6'h11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ST_W-1:0]  trn_state_i,
    input logic             trn_en_rb_i,
    input logic             phy_up_i,
    input logic             trn_en_o,
    input logic [CAP_W-1:0] speed_cap_o,
    input logic             link_up_o,
    input logic             link_lost_o,
    input logic             link_fail_o,
    input logic [ATT_W-1:0] attempt_o
);
    AST_UP_ONLY_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> (($past(trn_state_i) == ACTIVE_CODE) && $past(trn_en_rb_i) && $past(phy_up_i))); // R4

    AST_UP_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> trn_en_o); // R4

    AST_ATTEMPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trn_en_o) |-> ((attempt_o == ATT_W'(1)) || (attempt_o == $past(attempt_o) + 1'b1))); // R7

    AST_CAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_cap_o == CAP_W'(CAP_TOP)) || (speed_cap_o == CAP_W'(CAP_LOW))); // R8

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_o |=> link_fail_o); // R9

    AST_FAIL_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_o |-> (!trn_en_o && (attempt_o == ATT_W'(MAX_ATT)))); // R9

    AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost_o |=> !link_lost_o); // R10

    AST_LOST_FOLLOWS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost_o |-> ($past(link_up_o) && !link_up_o && !trn_en_o)); // R10
endmodule

bind lnk_bringup_sup lbs_checker #(
    .MAX_ATT     (MAX_ATT),
    .ATT_W       (ATT_W),
    .CAP_W       (CAP_W),
    .CAP_TOP     (CAP_TOP),
    .CAP_LOW     (CAP_LOW),
    .ST_W        (ST_W),
    .ACTIVE_CODE (ACTIVE_CODE)
) i_lbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .trn_state_i (trn_state_i),
    .trn_en_rb_i (trn_en_rb_i),
    .phy_up_i    (phy_up_i),
    .trn_en_o    (trn_en_o),
    .speed_cap_o (speed_cap_o),
    .link_up_o   (link_up_o),
    .link_lost_o (link_lost_o),
    .link_fail_o (link_fail_o),
    .attempt_o   (attempt_o)
);

// File: tb/test_lnk_bringup_sup.sv
module test_lnk_bringup_sup;
    localparam int P     = 8;
    localparam int NPOLL = 5;
    localparam int MAXA  = 3;
    localparam int HOLD  = 4;
    localparam int ATT_W = $clog2(MAXA + 1);

    localparam int K_GOOD  = 0;
    localparam int K_CLEAR = 1;
    localparam int K_STUCK = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             fb = 1'b0;
    logic [5:0]       ts = 6'h00;
    logic             rb = 1'b0;
    logic             phy = 1'b0;
    logic             trn_en_o;
    logic [1:0]       speed_cap_o;
    logic             link_up_o;
    logic             link_lost_o;
    logic             link_fail_o;
    logic [ATT_W-1:0] attempt_o;
    logic [5:0]       last_state_o;

    always #10 clk = ~clk;

    lnk_bringup_sup #(
        .POLL_CYC (P),
        .POLLS    (NPOLL),
        .MAX_ATT  (MAXA),
        .HOLD_CYC (HOLD)
    ) i_lnk_bringup_sup (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .fallback_i   (fb),
        .trn_state_i  (ts),
        .trn_en_rb_i  (rb),
        .phy_up_i     (phy),
        .trn_en_o     (trn_en_o),
        .speed_cap_o  (speed_cap_o),
        .link_up_o    (link_up_o),
        .link_lost_o  (link_lost_o),
        .link_fail_o  (link_fail_o),
        .attempt_o    (attempt_o),
        .last_state_o (last_state_o)
    );

    // Scenario description, written only by the stimulus process.
    int sc_kind [0:3];
    int sc_k    [0:3];
    int sc_loss;
    int exp_dur [0:3];
    int exp_up;

    // Counters: monitor and stimulus keep their own.
    int m_chk = 0, m_err = 0;
    int n_chk = 0, n_err = 0;

    // Monitor state, written only by the monitor process.
    int ecnt, lowcnt, mon_att, lost_cnt;
    bit prev_en, prev_up;

    // Link model and per-attempt monitor, all on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_en = 0; prev_up = 0; ecnt = 0; lowcnt = 0; mon_att = 0; lost_cnt = 0;
            ts <= 6'h00; rb <= 1'b0; phy <= 1'b0;
        end else begin
            if (trn_en_o) begin
                if (!prev_en) begin
                    mon_att++;
                    if (mon_att > 1) begin
                        m_chk++;
                        if (lowcnt != HOLD) begin
                            m_err++;
                            $display("FAIL R7 hold gap: actual %0d expected %0d", lowcnt, HOLD);
                        end
                    end
                    m_chk++;
                    if (int'(attempt_o) != mon_att) begin
                        m_err++;
                        $display("FAIL R7 attempt number: actual %0d expected %0d", attempt_o, mon_att);
                    end
                    m_chk++;
                    if (int'(speed_cap_o) != ((mon_att > 1 && fb) ? 1 : 2)) begin
                        m_err++;
                        $display("FAIL R8 cap at attempt %0d: actual %0d expected %0d",
                                 mon_att, speed_cap_o, (mon_att > 1 && fb) ? 1 : 2);
                    end
                    ecnt = 0;
                end
                ecnt++;
                case (sc_kind[mon_att])
                    K_GOOD: begin
                        if (sc_loss > 0 && ecnt >= sc_loss) begin
                            ts <= 6'h0D; rb <= 1'b1; phy <= 1'b0;
                        end else if (ecnt >= sc_k[mon_att]) begin
                            ts <= 6'h11; rb <= 1'b1; phy <= 1'b1;
                        end else begin
                            ts <= (ecnt < 3) ? 6'h01 : 6'h02; rb <= 1'b1; phy <= 1'b0;
                        end
                    end
                    K_CLEAR: begin
                        if (ecnt >= sc_k[mon_att]) begin
                            ts <= 6'h00; rb <= 1'b0; phy <= 1'b0;
                        end else begin
                            ts <= 6'h02; rb <= 1'b1; phy <= 1'b0;
                        end
                    end
                    default: begin
                        if (ecnt >= sc_k[mon_att]) begin
                            ts <= 6'h0E; rb <= 1'b1; phy <= 1'b1;
                        end else begin
                            ts <= 6'h0D; rb <= 1'b1; phy <= 1'b0;
                        end
                    end
                endcase
            end else begin
                if (prev_en) begin
                    m_chk++;
                    if (ecnt != exp_dur[mon_att]) begin
                        m_err++;
                        $display("FAIL R5/R6 enable-high length attempt %0d: actual %0d expected %0d",
                                 mon_att, ecnt, exp_dur[mon_att]);
                    end
                    lowcnt = 1;
                end else begin
                    lowcnt++;
                end
                ecnt = 0;
                ts <= 6'h00; rb <= 1'b0; phy <= 1'b0;
            end
            if (link_up_o && !prev_up) begin
                m_chk++;
                if (ecnt - 1 != exp_up) begin
                    m_err++;
                    $display("FAIL R4 link-up edge: actual %0d expected %0d", ecnt - 1, exp_up);
                end
            end
            if (link_lost_o) begin
                lost_cnt++;
                m_chk++;
                if (link_up_o || trn_en_o) begin
                    m_err++;
                    $display("FAIL R10 during loss pulse: up %0d en %0d expected 0 0", link_up_o, trn_en_o);
                end
            end
            prev_en = trn_en_o;
            prev_up = link_up_o;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int ceil_p(input int v);
        return ((v + P - 1) / P) * P;
    endfunction

    task automatic run_scn(input bit use_fb, input bit want_loss, input bit poke);
        int fg, e_att, e_cap, e_last;
        bit e_fail, done;
        fg = 0; exp_up = -100; sc_loss = 0;
        for (int a = 1; a <= MAXA; a++) begin
            exp_dur[a] = -1;
            if (fg == 0) begin
                case (sc_kind[a])
                    K_GOOD: begin
                        fg = a;
                        exp_up = ceil_p(sc_k[a]);
                        if (want_loss) begin
                            sc_loss = exp_up + 1 + int'($urandom_range(0, 2 * P - 1));
                            exp_dur[a] = ceil_p(sc_loss);
                        end
                    end
                    K_CLEAR: exp_dur[a] = ceil_p(sc_k[a]);
                    default: exp_dur[a] = NPOLL * P;
                endcase
            end
        end
        e_fail = (fg == 0);
        e_att  = e_fail ? MAXA : fg;
        e_cap  = (use_fb && fg != 1) ? 1 : 2;
        if (e_fail)            e_last = (sc_kind[MAXA] == K_STUCK) ? 6'h0E : 6'h00;
        else if (sc_loss > 0)  e_last = 6'h0D;
        else                   e_last = 6'h11;

        rst_n = 1'b0; start = 1'b0; fb = use_fb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!trn_en_o && !link_up_o && !link_lost_o && !link_fail_o && attempt_o == 0 &&
            last_state_o == 0 && speed_cap_o == 2, "R1 reset outputs", {trn_en_o, link_up_o, link_fail_o}, 0);

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 enable rises at the edge where start is taken
        chk(trn_en_o && attempt_o == 1 && speed_cap_o == 2, "R2 start from idle", int'(attempt_o), 1);

        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            chk(trn_en_o && attempt_o == 1, "R2 start ignored while training", int'(attempt_o), 1);
        end

        done = 0;
        for (int i = 0; i < 3000 && !done; i++) begin
            @(negedge clk);
            done = link_fail_o || (link_up_o && sc_loss == 0) || (lost_cnt > 0);
        end
        chk(done, "R6 sequence completes", int'(done), 1);
        repeat (2) @(negedge clk);

        if (sc_loss > 0) begin
            repeat (3 * P) @(negedge clk);
            chk(!trn_en_o && !link_up_o && attempt_o == ATT_W'(fg) && lost_cnt == 1,
                "R10 no retrain after loss", lost_cnt, 1);
        end
        chk(link_fail_o == e_fail, "R9 fail flag", int'(link_fail_o), int'(e_fail));
        chk(int'(attempt_o) == e_att, "R9 final attempt", int'(attempt_o), e_att);
        chk(int'(speed_cap_o) == e_cap, "R8 final cap", int'(speed_cap_o), e_cap);
        chk(int'(last_state_o) == e_last, "R3 last sampled state", int'(last_state_o), e_last);

        if (e_fail) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (HOLD + P) @(negedge clk);
            chk(link_fail_o && !trn_en_o && attempt_o == MAXA, "R9 start ignored after fail",
                int'(trn_en_o), 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int a = 0; a <= MAXA; a++) begin
            sc_kind[a] = K_STUCK; sc_k[a] = 1; exp_dur[a] = -1;
        end
        exp_up = -100; sc_loss = 0;

        // Directed: immediate active state on the first attempt (R4)
        sc_kind[1] = K_GOOD; sc_k[1] = 1;
        run_scn(1'b0, 1'b0, 1'b0);

        // Directed: two stuck attempts, active state on last poll of last attempt (R6, R8)
        sc_kind[1] = K_STUCK; sc_k[1] = 3;
        sc_kind[2] = K_STUCK; sc_k[2] = 1;
        sc_kind[3] = K_GOOD;  sc_k[3] = NPOLL * P;
        run_scn(1'b1, 1'b0, 1'b0);

        // Directed: every attempt self-clears, no fallback (R5, R8, R9)
        sc_kind[1] = K_CLEAR; sc_k[1] = 2;
        sc_kind[2] = K_CLEAR; sc_k[2] = P + 1;
        sc_kind[3] = K_CLEAR; sc_k[3] = NPOLL * P;
        run_scn(1'b0, 1'b0, 1'b0);

        // Directed: link drops after qualification (R10)
        sc_kind[1] = K_CLEAR; sc_k[1] = 5;
        sc_kind[2] = K_GOOD;  sc_k[2] = 2 * P;
        run_scn(1'b1, 1'b1, 1'b0);

        // Directed: start pulse during training is ignored (R2)
        sc_kind[1] = K_STUCK; sc_k[1] = 2;
        sc_kind[2] = K_GOOD;  sc_k[2] = 3;
        run_scn(1'b0, 1'b0, 1'b1);

        // Random mix of outcomes
        for (int s = 0; s < 30; s++) begin
            for (int a = 1; a <= MAXA; a++) begin
                int r;
                r = int'($urandom_range(0, 9));
                sc_kind[a] = (r < 4) ? K_GOOD : ((r < 7) ? K_CLEAR : K_STUCK);
                sc_k[a]    = int'($urandom_range(1, NPOLL * P));
            end
            run_scn(1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0), 1'b0);
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk + 1, n_err + m_err + 1);
        $finish;
    end
endmodule